// File: doc/BRIEF.md
# Memory Overlay Address Decoder

This block sits between a processor core and its memories. Each cycle it looks at one program-memory access and one data-memory access, both on 14-bit word addresses. It decides where each one goes: internal RAM, the bank of memory-mapped control registers, or a shared external bus. Two small overlay registers select which 8K external segment sits in a fixed 8K window. Software writes these registers through a simple write port. When an access goes to the external bus, the block produces the external address, a select and a read or write strobe.

The overlay value becomes the top bit of the external address, so overlay 1 maps the window to the lower external 8K and overlay 2 maps it to the upper 8K. A mode input turns program overlays off. A program access to the overlay window with no overlay selected is flagged as an error and issues no access. When both sides want the external bus in the same cycle, the program side gets the bus and the data side is stalled.

Top module: `mem_ovl_decoder`

## Requirements
- R1: After reset both overlay registers read as 0: program address 0x0000 goes to internal program RAM, program address 0x2000 raises `access_err`, and data address 0x0000 goes to internal data RAM.
- R2: A program access with address bit 13 = 0 (0x0000–0x1FFF) asserts `pm_int_sel` with `pm_int_addr` equal to address bits 12:0, whatever the overlay value.
- R3: A program access to 0x2000–0x3FFF while the effective program overlay is 1 or 2 asserts `ext_sel`. `ext_addr[12:0]` equals the core address bits 12:0, and `ext_addr[13]` is 0 for overlay 1 and 1 for overlay 2.
- R4: A program access to 0x2000–0x3FFF while the effective program overlay is 0 asserts `access_err` and asserts neither `pm_int_sel` nor `ext_sel`.
- R5: While `mode_no_ovl` is 1 the effective program overlay is 0. A write of a nonzero value to the program overlay register is ignored in that mode, and the register keeps its previous value.
- R6: A data access to 0x2000–0x3FDF asserts `dm_int_sel` with `dm_int_addr` equal to the core address.
- R7: A data access to 0x3FE0–0x3FFF asserts `dm_mmr_sel` with `dm_mmr_idx` equal to address bits 4:0, and never asserts `dm_int_sel`.
- R8: A data access to 0x0000–0x1FFF goes to the external bus when the data overlay is 1 or 2, with `ext_addr` formed as in R3. It goes to internal data RAM when the data overlay is 0.
- R9: The write port selects the register with `reg_sel` (0 = program overlay, 1 = data overlay). A write value of 3 or more is rejected, and the register keeps its previous value.
- R10: A register write takes effect at the clock edge that captures it. An access in the same cycle as the write is decoded with the old value, and an access in the next cycle uses the new value.
- R11: When program and data accesses both target the external bus in one cycle, the external bus carries the program access. `dm_stall` is 1, and the data side gets no internal or register select.
- R12: `ext_rd` is `ext_sel` with the winning access's write flag at 0, and `ext_wr` is `ext_sel` with that flag at 1. No select, strobe or error is asserted without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_no_ovl | input | 1 | 1 disables program overlays |
| reg_we | input | 1 | Overlay register write enable |
| reg_sel | input | 1 | 0 = program overlay, 1 = data overlay |
| reg_wdata | input | 4 | Overlay value to write |
| pm_req | input | 1 | Program-memory access valid |
| pm_we | input | 1 | Program-memory access is a write |
| pm_addr | input | 14 | Program-memory word address |
| dm_req | input | 1 | Data-memory access valid |
| dm_we | input | 1 | Data-memory access is a write |
| dm_addr | input | 14 | Data-memory word address |
| pm_int_sel | output | 1 | Program access goes to internal RAM |
| pm_int_addr | output | 13 | Internal program RAM word address |
| dm_int_sel | output | 1 | Data access goes to internal RAM |
| dm_int_addr | output | 14 | Internal data RAM word address |
| dm_mmr_sel | output | 1 | Data access hits a mapped control register |
| dm_mmr_idx | output | 5 | Mapped register index |
| ext_sel | output | 1 | External bus access this cycle |
| ext_addr | output | 14 | External word address |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| dm_stall | output | 1 | Data access held off by a program access |
| access_err | output | 1 | Program access to the reserved window |

## Verification
The hardest case to reach is a data access stalled on the external bus. Both overlay registers must first be set to nonzero values through the write port. Then a program access to the upper window and a data access to the lower window must arrive in the same cycle. The bench reaches it by writing both registers, then driving the two accesses together and checking that the external address carries the program side's overlay bit and low bits. A second hard case is a rejected write while the mode pin is high. This is observed by dropping the mode pin again and checking which external segment the program window then reaches.

// File: rtl/mem_ovl_pkg.sv
// Shared constants and route types for the overlay address decoder.
package mem_ovl_pkg;
    localparam int ADDR_W    = 14;
    localparam int WDATA_W   = 4;
    localparam int OVL_W     = 2;
    localparam int OVL_MAX   = 2;
    localparam int MMR_COUNT = 32;

    typedef enum logic [1:0] {
        PM_IDLE = 2'd0,
        PM_INT  = 2'd1,
        PM_EXT  = 2'd2,
        PM_ERR  = 2'd3
    } pm_route_t;

    typedef enum logic [1:0] {
        DM_IDLE = 2'd0,
        DM_INT  = 2'd1,
        DM_MMR  = 2'd2,
        DM_EXT  = 2'd3
    } dm_route_t;
endpackage

// File: rtl/mem_ovl_regs.sv
// Overlay select registers (program and data).
// Assumes: values above MAX_VAL are rejected; when lock_pm is high only
// a zero may be written to the program register. Synchronous active-low reset.
module mem_ovl_regs #(
    parameter int WDATA_W = 4,
    parameter int OVL_W   = 2,
    parameter int MAX_VAL = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_pm,
    input  logic               we,
    input  logic               sel,
    input  logic [WDATA_W-1:0] wdata,
    output logic [OVL_W-1:0]   pm_ovl,
    output logic [OVL_W-1:0]   dm_ovl
);
    localparam int NREG = 2;

    logic [OVL_W-1:0] ovl_q [NREG];
    logic             in_range;

    // Purpose: flag write values inside the legal overlay range
    always_comb begin
        in_range = (wdata <= WDATA_W'(MAX_VAL));
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic accept;
        // Purpose: qualify a write for this register, honouring the mode lock
        always_comb begin
            accept = we && (sel == i[0]) && in_range;
            if (i == 0 && lock_pm && (wdata != '0)) accept = 1'b0;
        end
        // Purpose: hold the overlay value, cleared at reset
        always_ff @(posedge clk) begin
            if (!rst_n)      ovl_q[i] <= '0;
            else if (accept) ovl_q[i] <= wdata[OVL_W-1:0];
        end
    end

    assign pm_ovl = ovl_q[0];
    assign dm_ovl = ovl_q[1];
endmodule

// File: rtl/mem_ovl_pm_dec.sv
// Program-memory route decoder.
// Assumes: the lower half of the space is internal RAM and the upper half
// is the overlay window; an overlay value of 0 leaves the window reserved.
module mem_ovl_pm_dec
    import mem_ovl_pkg::*;
#(
    parameter int AW    = 14,
    parameter int OVL_W = 2
) (
    input  logic             req,
    input  logic [AW-1:0]    addr,
    input  logic [OVL_W-1:0] ovl_eff,
    output pm_route_t        route
);
    // Purpose: pick internal, external or error from the window bit
    always_comb begin
        if (!req)                route = PM_IDLE;
        else if (!addr[AW-1])    route = PM_INT;
        else if (ovl_eff != '0)  route = PM_EXT;
        else                     route = PM_ERR;
    end
endmodule

// File: rtl/mem_ovl_dm_dec.sv
// Data-memory route decoder.
// Assumes: the top MMR_N words are mapped registers, the rest of the upper
// half is internal RAM, and the lower half is the overlay window.
module mem_ovl_dm_dec
    import mem_ovl_pkg::*;
#(
    parameter int AW    = 14,
    parameter int OVL_W = 2,
    parameter int MMR_N = 32
) (
    input  logic             req,
    input  logic [AW-1:0]    addr,
    input  logic [OVL_W-1:0] ovl,
    output dm_route_t        route
);
    localparam int          MMR_W    = $clog2(MMR_N);
    localparam logic [AW-1:0] MMR_BASE = AW'((1 << AW) - MMR_N);

    logic in_mmr;

    // Purpose: detect the mapped-register block at the top of the space
    always_comb begin
        in_mmr = (addr >= MMR_BASE);
    end

    // Purpose: pick internal RAM, mapped register or external bus
    always_comb begin
        if (!req)               route = DM_IDLE;
        else if (addr[AW-1])    route = in_mmr ? DM_MMR : DM_INT;
        else if (ovl != '0)     route = DM_EXT;
        else                    route = DM_INT;
    end

    logic unused_w;
    assign unused_w = ^MMR_W;
endmodule

// File: rtl/mem_ovl_ext_arb.sv
// External bus arbiter and address former.
// Assumes: program side always wins; overlay value 2 sets the top bit.
module mem_ovl_ext_arb #(
    parameter int AW    = 14,
    parameter int OVL_W = 2
) (
    input  logic             pm_ext,
    input  logic             pm_we,
    input  logic [AW-1:0]    pm_addr,
    input  logic [OVL_W-1:0] pm_ovl,
    input  logic             dm_ext,
    input  logic             dm_we,
    input  logic [AW-1:0]    dm_addr,
    input  logic [OVL_W-1:0] dm_ovl,
    output logic             ext_sel,
    output logic [AW-1:0]    ext_addr,
    output logic             ext_rd,
    output logic             ext_wr,
    output logic             dm_stall
);
    localparam int WIN_W = AW - 1;

    logic win_we;

    // Purpose: grant the bus, program side first, and form the address
    always_comb begin
        ext_sel  = pm_ext | dm_ext;
        dm_stall = pm_ext & dm_ext;
        if (pm_ext) begin
            ext_addr = {pm_ovl == OVL_W'(2), pm_addr[WIN_W-1:0]};
            win_we   = pm_we;
        end else if (dm_ext) begin
            ext_addr = {dm_ovl == OVL_W'(2), dm_addr[WIN_W-1:0]};
            win_we   = dm_we;
        end else begin
            ext_addr = '0;
            win_we   = 1'b0;
        end
        ext_rd = ext_sel & ~win_we;
        ext_wr = ext_sel &  win_we;
    end
endmodule

// File: rtl/mem_ovl_decoder.sv
// Memory overlay address decoder top.
// Routes program and data accesses to internal RAM, mapped registers or the
// external bus using two overlay registers. Decoding is combinational from
// the registered overlay values. Synchronous active-low reset.
module mem_ovl_decoder
    import mem_ovl_pkg::*;
#(
    parameter int AW    = mem_ovl_pkg::ADDR_W,
    parameter int WD_W  = mem_ovl_pkg::WDATA_W,
    parameter int OVL_W = mem_ovl_pkg::OVL_W,
    parameter int MMR_N = mem_ovl_pkg::MMR_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_no_ovl,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [WD_W-1:0]    reg_wdata,
    input  logic               pm_req,
    input  logic               pm_we,
    input  logic [AW-1:0]      pm_addr,
    input  logic               dm_req,
    input  logic               dm_we,
    input  logic [AW-1:0]      dm_addr,
    output logic               pm_int_sel,
    output logic [AW-2:0]      pm_int_addr,
    output logic               dm_int_sel,
    output logic [AW-1:0]      dm_int_addr,
    output logic               dm_mmr_sel,
    output logic [$clog2(MMR_N)-1:0] dm_mmr_idx,
    output logic               ext_sel,
    output logic [AW-1:0]      ext_addr,
    output logic               ext_rd,
    output logic               ext_wr,
    output logic               dm_stall,
    output logic               access_err
);
    localparam int MMR_W = $clog2(MMR_N);

    logic [OVL_W-1:0] ovl_pm;
    logic [OVL_W-1:0] ovl_dm;
    logic [OVL_W-1:0] ovl_pm_eff;
    pm_route_t        pm_route;
    dm_route_t        dm_route;

    mem_ovl_regs #(.WDATA_W(WD_W), .OVL_W(OVL_W), .MAX_VAL(OVL_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .lock_pm(mode_no_ovl),
        .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .pm_ovl(ovl_pm), .dm_ovl(ovl_dm)
    );

    // Purpose: force the program overlay off while the mode pin is high
    always_comb begin
        ovl_pm_eff = mode_no_ovl ? '0 : ovl_pm;
    end

    mem_ovl_pm_dec #(.AW(AW), .OVL_W(OVL_W)) u_pm_dec (
        .req(pm_req), .addr(pm_addr), .ovl_eff(ovl_pm_eff), .route(pm_route)
    );

    mem_ovl_dm_dec #(.AW(AW), .OVL_W(OVL_W), .MMR_N(MMR_N)) u_dm_dec (
        .req(dm_req), .addr(dm_addr), .ovl(ovl_dm), .route(dm_route)
    );

    mem_ovl_ext_arb #(.AW(AW), .OVL_W(OVL_W)) u_arb (
        .pm_ext(pm_route == PM_EXT), .pm_we(pm_we), .pm_addr(pm_addr),
        .pm_ovl(ovl_pm_eff),
        .dm_ext(dm_route == DM_EXT), .dm_we(dm_we), .dm_addr(dm_addr),
        .dm_ovl(ovl_dm),
        .ext_sel(ext_sel), .ext_addr(ext_addr), .ext_rd(ext_rd),
        .ext_wr(ext_wr), .dm_stall(dm_stall)
    );

    // Purpose: drive the internal and register-side selects
    always_comb begin
        pm_int_sel  = (pm_route == PM_INT);
        pm_int_addr = pm_addr[AW-2:0];
        access_err  = (pm_route == PM_ERR);
        dm_int_sel  = (dm_route == DM_INT);
        dm_int_addr = dm_addr;
        dm_mmr_sel  = (dm_route == DM_MMR);
        dm_mmr_idx  = dm_addr[MMR_W-1:0];
    end
endmodule

// File: rtl/mem_ovl_decoder_chk.sv
// Assertion checker for the overlay decoder, bound to the top module.
module mem_ovl_decoder_chk #(
    parameter int AW    = 14,
    parameter int WD_W  = 4,
    parameter int OVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_no_ovl,
    input logic             reg_we,
    input logic             reg_sel,
    input logic [WD_W-1:0]  reg_wdata,
    input logic             pm_req,
    input logic [AW-1:0]    pm_addr,
    input logic             dm_req,
    input logic [AW-1:0]    dm_addr,
    input logic             pm_int_sel,
    input logic             dm_int_sel,
    input logic             dm_mmr_sel,
    input logic             ext_sel,
    input logic [AW-1:0]    ext_addr,
    input logic             ext_rd,
    input logic             ext_wr,
    input logic             dm_stall,
    input logic             access_err,
    input logic [OVL_W-1:0] ovl_pm,
    input logic [OVL_W-1:0] ovl_dm
);
    localparam logic [AW-1:0] MMR_BASE = AW'((1 << AW) - 32);

    AST_PM_LOW_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req && !pm_addr[AW-1]) |-> (pm_int_sel && !access_err)); // R2
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> (!pm_int_sel && !(ext_sel && !dm_req))); // R4
    AST_MODE_BLOCKS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_no_ovl && pm_req && pm_addr[AW-1]) |-> access_err); // R5
    AST_MODE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_no_ovl && reg_we && !reg_sel && reg_wdata != '0) |=> $stable(ovl_pm)); // R5
    AST_MMR_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && dm_addr >= MMR_BASE) |-> (dm_mmr_sel && !dm_int_sel)); // R7
    AST_BAD_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata > WD_W'(2)) |=> ($stable(ovl_pm) && $stable(ovl_dm))); // R9
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(ovl_pm) && $stable(ovl_dm))); // R10
    AST_STALL_PM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dm_stall |-> (ext_sel && ext_addr[AW-2:0] == pm_addr[AW-2:0]
                      && !dm_int_sel && !dm_mmr_sel)); // R11
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({ext_rd, ext_wr}) == 32'(ext_sel))); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_req && !dm_req) |-> $onehot0({ext_sel, access_err, pm_int_sel}) && !ext_sel
                                 && !access_err && !pm_int_sel && !dm_int_sel); // R12
endmodule

bind mem_ovl_decoder mem_ovl_decoder_chk #(.AW(AW), .WD_W(WD_W), .OVL_W(OVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_no_ovl(mode_no_ovl), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .pm_req(pm_req), .pm_addr(pm_addr),
    .dm_req(dm_req), .dm_addr(dm_addr), .pm_int_sel(pm_int_sel),
    .dm_int_sel(dm_int_sel), .dm_mmr_sel(dm_mmr_sel), .ext_sel(ext_sel),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr), .dm_stall(dm_stall),
    .access_err(access_err), .ovl_pm(ovl_pm), .ovl_dm(ovl_dm)
);

// File: tb/mem_ovl_decoder_tb.sv
// Directed bench for the overlay decoder: one task per scenario.
module mem_ovl_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_no_ovl = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [3:0]  reg_wdata = '0;
    logic        pm_req = 1'b0, pm_we = 1'b0;
    logic [13:0] pm_addr = '0;
    logic        dm_req = 1'b0, dm_we = 1'b0;
    logic [13:0] dm_addr = '0;
    logic        pm_int_sel, dm_int_sel, dm_mmr_sel, ext_sel, ext_rd, ext_wr;
    logic        dm_stall, access_err;
    logic [12:0] pm_int_addr;
    logic [13:0] dm_int_addr, ext_addr;
    logic [4:0]  dm_mmr_idx;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;

    mem_ovl_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .mode_no_ovl(mode_no_ovl), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .pm_req(pm_req), .pm_we(pm_we),
        .pm_addr(pm_addr), .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
        .pm_int_sel(pm_int_sel), .pm_int_addr(pm_int_addr), .dm_int_sel(dm_int_sel),
        .dm_int_addr(dm_int_addr), .dm_mmr_sel(dm_mmr_sel), .dm_mmr_idx(dm_mmr_idx),
        .ext_sel(ext_sel), .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .dm_stall(dm_stall), .access_err(access_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Drive a register write across one rising edge, inputs at falling edge.
    task automatic wr_reg(input logic sel, input logic [3:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle();
        pm_req = 0; dm_req = 0; pm_we = 0; dm_we = 0;
    endtask

    task automatic pm_acc(input logic [13:0] a, input logic w);
        pm_req = 1; pm_addr = a; pm_we = w; dm_req = 0; #1;
    endtask

    task automatic dm_acc(input logic [13:0] a, input logic w);
        dm_req = 1; dm_addr = a; dm_we = w; pm_req = 0; #1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        pm_acc(14'h0000, 0);
        chk("R1 pm 0x0000 internal", pm_int_sel, 1);
        pm_acc(14'h2000, 0);
        chk("R1 pm window err", access_err, 1);
        dm_acc(14'h0000, 0);
        chk("R1 dm 0x0000 internal", dm_int_sel, 1);
        idle();
    endtask

    task automatic t_pm_internal();
        wr_reg(0, 4'd2);
        pm_acc(14'h1ABC, 0);
        chk("R2 pm low sel", pm_int_sel, 1);
        chk("R2 pm low addr", pm_int_addr, 13'h1ABC);
        chk("R2 pm low no ext", ext_sel, 0);
        idle();
    endtask

    task automatic t_pm_overlay();
        wr_reg(0, 4'd1);
        @(negedge clk);
        pm_acc(14'h2345, 0);
        chk("R3 ovl1 ext_sel", ext_sel, 1);
        chk("R3 ovl1 addr", ext_addr, 14'h0345);
        chk("R12 read strobe", {ext_rd, ext_wr}, 2'b10);
        wr_reg(0, 4'd2);
        pm_acc(14'h3FFF, 1);
        chk("R3 ovl2 addr", ext_addr, 14'h3FFF);
        chk("R12 write strobe", {ext_rd, ext_wr}, 2'b01);
        idle();
    endtask

    task automatic t_pm_reserved();
        wr_reg(0, 4'd0);
        pm_acc(14'h2800, 0);
        chk("R4 err", access_err, 1);
        chk("R4 no int", pm_int_sel, 0);
        chk("R4 no ext", ext_sel, 0);
        idle();
    endtask

    task automatic t_mode();
        wr_reg(0, 4'd1);
        mode_no_ovl = 1;
        pm_acc(14'h2000, 0);
        chk("R5 mode forces err", access_err, 1);
        wr_reg(0, 4'd2);
        mode_no_ovl = 0;
        pm_acc(14'h2001, 0);
        chk("R5 write ignored, ovl1 kept", ext_addr, 14'h0001);
        mode_no_ovl = 1;
        wr_reg(0, 4'd0);
        mode_no_ovl = 0;
        pm_acc(14'h2001, 0);
        chk("R5 zero write accepted", access_err, 1);
        idle();
    endtask

    task automatic t_dm_map();
        dm_acc(14'h2000, 0);
        chk("R6 dm ram low", {dm_int_sel, dm_mmr_sel}, 2'b10);
        dm_acc(14'h3FDF, 0);
        chk("R6 dm ram top", {dm_int_sel, dm_mmr_sel}, 2'b10);
        chk("R6 dm addr", dm_int_addr, 14'h3FDF);
        dm_acc(14'h3FE0, 0);
        chk("R7 mmr first", {dm_int_sel, dm_mmr_sel, 5'(dm_mmr_idx)}, {2'b01, 5'd0});
        dm_acc(14'h3FFF, 1);
        chk("R7 mmr last", {dm_int_sel, dm_mmr_sel, 5'(dm_mmr_idx)}, {2'b01, 5'd31});
        idle();
    endtask

    task automatic t_dm_overlay();
        wr_reg(1, 4'd2);
        dm_acc(14'h0123, 1);
        chk("R8 dm ovl2 ext", {ext_sel, dm_int_sel}, 2'b10);
        chk("R8 dm ovl2 addr", ext_addr, 14'h2123);
        wr_reg(1, 4'd1);
        dm_acc(14'h1FFF, 0);
        chk("R8 dm ovl1 addr", ext_addr, 14'h1FFF);
        wr_reg(1, 4'd0);
        dm_acc(14'h1FFF, 0);
        chk("R8 dm ovl0 internal", {ext_sel, dm_int_sel}, 2'b01);
        idle();
    endtask

    task automatic t_bad_write();
        wr_reg(1, 4'd1);
        wr_reg(1, 4'd3);
        dm_acc(14'h0010, 0);
        chk("R9 value 3 rejected", ext_addr, 14'h0010);
        wr_reg(1, 4'd9);
        dm_acc(14'h0010, 0);
        chk("R9 value 9 rejected", {ext_sel, ext_addr[13]}, 2'b10);
        idle();
    endtask

    task automatic t_timing();
        wr_reg(0, 4'd0);
        @(negedge clk);
        reg_we = 1; reg_sel = 0; reg_wdata = 4'd2;
        pm_acc(14'h2222, 0);
        chk("R10 same cycle old value", access_err, 1);
        @(posedge clk); #1;
        chk("R10 next cycle new value", ext_addr, 14'h2222);
        @(negedge clk);
        reg_we = 0;
        idle();
    endtask

    task automatic t_conflict();
        wr_reg(0, 4'd1);
        wr_reg(1, 4'd2);
        pm_req = 1; pm_addr = 14'h2AAA; pm_we = 0;
        dm_req = 1; dm_addr = 14'h0555; dm_we = 1; #1;
        chk("R11 stall", dm_stall, 1);
        chk("R11 pm address wins", ext_addr, 14'h0AAA);
        chk("R11 pm strobe", {ext_rd, ext_wr}, 2'b10);
        chk("R11 dm no sel", {dm_int_sel, dm_mmr_sel}, 2'b00);
        pm_req = 0; #1;
        chk("R11 dm alone gets bus", {dm_stall, ext_addr}, {1'b0, 14'h2555});
        idle(); #1;
        chk("R12 idle quiet", {ext_sel, ext_rd, ext_wr, access_err, pm_int_sel, dm_int_sel, dm_mmr_sel}, 7'b0);
    endtask

    initial begin
        t_reset();
        t_pm_internal();
        t_pm_overlay();
        t_pm_reserved();
        t_mode();
        t_dm_map();
        t_dm_overlay();
        t_bad_write();
        t_timing();
        t_conflict();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule